// File: doc/BRIEF.md
# Programmable Down-Counting Interval Timer

A 32-bit interval timer reached through a plain single-cycle register port: an address, a write strobe, write data, and a registered read-data bus. Software picks one of three tick-enable inputs as the count source and sets a start value in a load register. The counter then steps down by one on each qualified tick. On reaching zero it either reloads from the load register or wraps to all ones and keeps running.

A compare register is checked against every value the counter steps to. A match latches a status flag, and software clears that flag by writing a one to it. An interrupt line follows the flag whenever the interrupt enable is set. Three low-power request inputs (stop, wait, debug) freeze counting unless the matching run bit permits it.

A self-clearing soft reset puts every register back to its default. During this reset the block ignores bus writes, and the soft-reset bit reads as one. All sources and the bus share one clock. Each clock source is modelled as a one-cycle tick enable.

Top module: `ivt_timer`

## Requirements
- R1: After reset the registers read as follows: control 0, status 0, compare 0, load 0xFFFFFFFF, counter 0xFFFFFFFF.
- R2: The register map uses these byte offsets: control 0x00, status 0x04, load 0x08, compare 0x0C, counter 0x10. The counter cannot be written. A read returns the register value on `bus_rdata` one clock after the address is presented.
- R3: Control bits 25:24 select the count source: 0 = none, 1 = `tick_bus`, 2 = `tick_hf`, 3 = `tick_lf`. With enable (control bit 0) set, the counter decrements once per pulse of the selected source. Pulses on the other sources have no effect.
- R4: With reload-select (control bit 3) set, a tick that arrives while the counter is 0 loads the counter from the load register.
- R5: With reload-select clear, a tick that arrives while the counter is 0 wraps the counter to 0xFFFFFFFF.
- R6: A control write that sets enable while enable is clear loads the counter from the load register, provided enable-mode (control bit 1) is set in that same write. If enable-mode is clear, the counter keeps its value.
- R7: With immediate-overwrite (control bit 17) set, a write to the load register also writes the counter in the same cycle. With the bit clear, the counter is untouched by load writes.
- R8: Status bit 0 is set by a tick that moves the counter onto the compare value. Writing 1 to status bit 0 clears it. Writing 0 to it leaves it unchanged.
- R9: `irq` is high exactly when status bit 0 and the interrupt enable (control bit 2) are both 1.
- R10: Counting halts in any of these cases: the source field is 0; enable is clear; `stop_req`, `wait_req` or `dbg_req` is high while its run bit is clear. The run bits are stop 21, wait 19 and debug 18.
- R11: Writing 1 to control bit 16 resets all registers to their defaults. Bit 16 then reads 1 for exactly 3 clocks and afterwards reads 0. Bus writes made during those 3 clocks are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by the bus and all tick sources |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| tick_bus | input | 1 | Tick enable for source 1 |
| tick_hf | input | 1 | Tick enable for source 2 |
| tick_lf | input | 1 | Tick enable for source 3 |
| stop_req | input | 1 | Stop-mode request |
| wait_req | input | 1 | Wait-mode request |
| dbg_req | input | 1 | Debug-halt request |
| irq | output | 1 | Compare interrupt |

## Verification
The hardest behaviour to observe from the ports is the soft-reset window. It lasts only three clocks, and both the busy bit and the ignored write must be seen inside it. The stimulus therefore runs back-to-back single-cycle operations with no idle cycles: the soft-reset write, a control read, a load write, then two more control reads. This places the write and the reads on known cycles inside the window and on the first cycle after it. The compare flag is also driven through the reload and wrap paths by long tick bursts, so the flag is seen being set by a pass through the compare value rather than by a direct load.

// File: rtl/ivt_pkg.sv
package ivt_pkg;
  // register index = byte offset / 4
  localparam int IDX_CTRL = 0;
  localparam int IDX_STAT = 1;
  localparam int IDX_LOAD = 2;
  localparam int IDX_CMP  = 3;
  localparam int IDX_CNT  = 4;

  // control bit positions
  localparam int B_EN    = 0;
  localparam int B_ENMOD = 1;
  localparam int B_IEN   = 2;
  localparam int B_RLD   = 3;
  localparam int B_SRST  = 16;
  localparam int B_IOVW  = 17;
  localparam int B_DBG   = 18;
  localparam int B_WAIT  = 19;
  localparam int B_STOP  = 21;
  localparam int B_SRC   = 24;

  typedef struct packed {
    logic [1:0] src;
    logic       stop_run;
    logic       wait_run;
    logic       dbg_run;
    logic       iovw;
    logic       rld;
    logic       ien;
    logic       enmod;
    logic       en;
  } ctrl_t;

  function automatic logic [31:0] ctrl_pack(ctrl_t c);
    logic [31:0] r;
    r = '0;
    r[B_EN]           = c.en;
    r[B_ENMOD]        = c.enmod;
    r[B_IEN]          = c.ien;
    r[B_RLD]          = c.rld;
    r[B_IOVW]         = c.iovw;
    r[B_DBG]          = c.dbg_run;
    r[B_WAIT]         = c.wait_run;
    r[B_STOP]         = c.stop_run;
    r[B_SRC+1:B_SRC]  = c.src;
    return r;
  endfunction

  function automatic ctrl_t ctrl_unpack(logic [31:0] w);
    ctrl_t c;
    c.en       = w[B_EN];
    c.enmod    = w[B_ENMOD];
    c.ien      = w[B_IEN];
    c.rld      = w[B_RLD];
    c.iovw     = w[B_IOVW];
    c.dbg_run  = w[B_DBG];
    c.wait_run = w[B_WAIT];
    c.stop_run = w[B_STOP];
    c.src      = w[B_SRC+1:B_SRC];
    return c;
  endfunction
endpackage

// File: rtl/ivt_tick.sv
module ivt_tick
  import ivt_pkg::*;
#(
  parameter int NSRC = 4
) (
  input  logic  tick_bus,
  input  logic  tick_hf,
  input  logic  tick_lf,
  input  logic  stop_req,
  input  logic  wait_req,
  input  logic  dbg_req,
  input  ctrl_t ctrl,
  output logic  tick_ok
);
  localparam int SW = $clog2(NSRC);

  logic [NSRC-1:0] src_vec;
  logic            src_tick;
  logic            halted;

  // source 0 never ticks
  assign src_vec = NSRC'({tick_lf, tick_hf, tick_bus, 1'b0});
  assign src_tick = src_vec[SW'(ctrl.src)];

  assign halted = (stop_req && !ctrl.stop_run) ||
                  (wait_req && !ctrl.wait_run) ||
                  (dbg_req  && !ctrl.dbg_run);

  assign tick_ok = ctrl.en && src_tick && !halted;
endmodule

// File: rtl/ivt_core.sv
module ivt_core #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          hold,
  input  logic          ld_now,
  input  logic [DW-1:0] ld_val,
  input  logic          en_load,
  input  logic [DW-1:0] load_q,
  input  logic          tick_ok,
  input  logic          rld,
  input  logic [DW-1:0] cmp_q,
  output logic [DW-1:0] cnt_q,
  output logic          cmp_hit
);
  localparam logic [DW-1:0] ONES = '1;

  logic [DW-1:0] step_val;

  always_comb begin
    if (cnt_q == '0) step_val = rld ? load_q : ONES;
    else             step_val = cnt_q - 1'b1;
  end

  assign cmp_hit = tick_ok && !ld_now && !en_load && !hold && (step_val == cmp_q);

  always_ff @(posedge clk) begin
    if (rst || hold)  cnt_q <= ONES;
    else if (ld_now)  cnt_q <= ld_val;
    else if (en_load) cnt_q <= load_q;
    else if (tick_ok) cnt_q <= step_val;
  end
endmodule

// File: rtl/ivt_regs.sv
module ivt_regs
  import ivt_pkg::*;
#(
  parameter int DW       = 32,
  parameter int AW       = 5,
  parameter int SRST_CYC = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          cmp_hit,
  output ctrl_t         ctrl_q,
  output logic [DW-1:0] load_q,
  output logic [DW-1:0] cmp_q,
  output logic          flag_q,
  output logic          busy,
  output logic          srst_cmd,
  output logic          en_load,
  output logic          ld_now
);
  localparam int CW = $clog2(SRST_CYC + 1);
  localparam logic [DW-1:0] ONES = '1;

  logic [CW-1:0]  busy_cnt;
  logic           wr_ok;
  int             sel;
  ctrl_t          w_ctrl;

  assign sel      = int'(addr[AW-1:2]);
  assign busy     = (busy_cnt != '0);
  assign wr_ok    = wr && !busy;
  assign w_ctrl   = ctrl_unpack(wdata);
  assign srst_cmd = wr_ok && (sel == IDX_CTRL) && wdata[B_SRST];
  assign en_load  = wr_ok && (sel == IDX_CTRL) && !wdata[B_SRST] &&
                    w_ctrl.en && w_ctrl.enmod && !ctrl_q.en;
  assign ld_now   = wr_ok && (sel == IDX_LOAD) && ctrl_q.iovw;

  always_ff @(posedge clk) begin
    if (rst || srst_cmd) begin
      ctrl_q   <= '0;
      load_q   <= ONES;
      cmp_q    <= '0;
      flag_q   <= 1'b0;
      busy_cnt <= rst ? '0 : CW'(SRST_CYC);
    end else begin
      if (busy) busy_cnt <= busy_cnt - 1'b1;
      if (wr_ok) begin
        case (sel)
          IDX_CTRL: ctrl_q <= w_ctrl;
          IDX_LOAD: load_q <= wdata;
          IDX_CMP:  cmp_q  <= wdata;
          default: ;
        endcase
      end
      if (cmp_hit)
        flag_q <= 1'b1;
      else if (wr_ok && (sel == IDX_STAT) && wdata[0])
        flag_q <= 1'b0;
    end
  end
endmodule

// File: rtl/ivt_timer.sv
module ivt_timer
  import ivt_pkg::*;
#(
  parameter int DW       = 32,
  parameter int AW       = 5,
  parameter int SRST_CYC = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          tick_bus,
  input  logic          tick_hf,
  input  logic          tick_lf,
  input  logic          stop_req,
  input  logic          wait_req,
  input  logic          dbg_req,
  output logic          irq
);
  ctrl_t         ctrl_q;
  logic [DW-1:0] load_q, cmp_q, cnt_q;
  logic          flag_q, busy, srst_cmd, en_load, ld_now;
  logic          tick_ok, cmp_hit;
  int            rsel;

  ivt_regs #(.DW(DW), .AW(AW), .SRST_CYC(SRST_CYC)) u_regs (
    .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata),
    .cmp_hit(cmp_hit), .ctrl_q(ctrl_q), .load_q(load_q), .cmp_q(cmp_q),
    .flag_q(flag_q), .busy(busy), .srst_cmd(srst_cmd), .en_load(en_load),
    .ld_now(ld_now)
  );

  ivt_tick #(.NSRC(4)) u_tick (
    .tick_bus(tick_bus), .tick_hf(tick_hf), .tick_lf(tick_lf),
    .stop_req(stop_req), .wait_req(wait_req), .dbg_req(dbg_req),
    .ctrl(ctrl_q), .tick_ok(tick_ok)
  );

  ivt_core #(.DW(DW)) u_core (
    .clk(clk), .rst(rst), .hold(srst_cmd || busy), .ld_now(ld_now),
    .ld_val(bus_wdata), .en_load(en_load), .load_q(load_q),
    .tick_ok(tick_ok), .rld(ctrl_q.rld), .cmp_q(cmp_q),
    .cnt_q(cnt_q), .cmp_hit(cmp_hit)
  );

  assign rsel = int'(bus_addr[AW-1:2]);
  assign irq  = flag_q && ctrl_q.ien;

  always_ff @(posedge clk) begin
    if (rst) bus_rdata <= '0;
    else begin
      case (rsel)
        IDX_CTRL: bus_rdata <= DW'(ctrl_pack(ctrl_q)) | (DW'(busy) << B_SRST);
        IDX_STAT: bus_rdata <= DW'(flag_q);
        IDX_LOAD: bus_rdata <= load_q;
        IDX_CMP:  bus_rdata <= cmp_q;
        IDX_CNT:  bus_rdata <= cnt_q;
        default:  bus_rdata <= '0;
      endcase
    end
  end
endmodule

// File: rtl/ivt_chk.sv
module ivt_chk #(
  parameter int DW = 32,
  parameter int AW = 5
) (
  input logic          clk,
  input logic          rst,
  input logic          irq,
  input logic          flag,
  input logic          ien,
  input logic          en,
  input logic          rld,
  input logic          busy,
  input logic          tick_ok,
  input logic          wr,
  input logic [AW-1:0] addr,
  input logic [DW-1:0] wdata,
  input logic [DW-1:0] load_q,
  input logic [DW-1:0] cnt_q
);
  // R9
  irq_match_chk: assert property (@(posedge clk) disable iff (rst)
    irq == (flag && ien));

  // R8
  w1c_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && wr && (addr[AW-1:2] == 3'd1) && !wdata[0]) |=> flag);

  // R11
  srst_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && wr && (addr[AW-1:2] == 3'd2)) |=> $stable(load_q));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!en && !wr && !busy) |=> $stable(cnt_q));

  // R5
  wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (tick_ok && (cnt_q == '0) && !rld && !wr) |=> (cnt_q == '1));
endmodule

bind ivt_timer ivt_chk #(.DW(DW), .AW(AW)) u_chk (
  .clk(clk), .rst(rst), .irq(irq), .flag(flag_q), .ien(ctrl_q.ien),
  .en(ctrl_q.en), .rld(ctrl_q.rld), .busy(busy), .tick_ok(tick_ok),
  .wr(bus_wr), .addr(bus_addr), .wdata(bus_wdata), .load_q(load_q),
  .cnt_q(cnt_q)
);

// File: tb/sim_ivt_timer.sv
module sim_ivt_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        tick_bus = 0, tick_hf = 0, tick_lf = 0;
  logic        stop_req = 0, wait_req = 0, dbg_req = 0;
  logic        irq;

  int n_run = 0;
  int n_fail = 0;

  always #2 clk = ~clk;

  ivt_timer u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tick_bus(tick_bus),
    .tick_hf(tick_hf), .tick_lf(tick_lf), .stop_req(stop_req),
    .wait_req(wait_req), .dbg_req(dbg_req), .irq(irq)
  );

  typedef struct packed {
    logic [1:0]  op;   // 0 write, 1 read+check, 2 bus ticks, 3 hf ticks
    logic [4:0]  addr;
    logic [31:0] data;
    logic [31:0] exp;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 51;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 5'h00, 32'h0, 32'h0,        4'd1},  // R1
    '{2'd1, 5'h04, 32'h0, 32'h0,        4'd1},  // R1
    '{2'd1, 5'h08, 32'h0, 32'hFFFFFFFF, 4'd1},  // R1
    '{2'd1, 5'h0C, 32'h0, 32'h0,        4'd1},  // R1
    '{2'd1, 5'h10, 32'h0, 32'hFFFFFFFF, 4'd1},  // R1
    '{2'd0, 5'h08, 32'd10, 32'h0,       4'd2},
    '{2'd0, 5'h0C, 32'd7, 32'h0,        4'd2},
    '{2'd1, 5'h08, 32'h0, 32'd10,       4'd2},  // R2
    '{2'd1, 5'h0C, 32'h0, 32'd7,        4'd2},  // R2
    '{2'd0, 5'h00, 32'h0100000B, 32'h0, 4'd6},
    '{2'd1, 5'h00, 32'h0, 32'h0100000B, 4'd2},  // R2
    '{2'd1, 5'h10, 32'h0, 32'd10,       4'd6},  // R6 load on enable
    '{2'd0, 5'h10, 32'h55, 32'h0,       4'd2},
    '{2'd1, 5'h10, 32'h0, 32'd10,       4'd2},  // R2 counter read-only
    '{2'd2, 5'h00, 32'd3, 32'h0,        4'd3},
    '{2'd1, 5'h10, 32'h0, 32'd7,        4'd3},  // R3
    '{2'd1, 5'h04, 32'h0, 32'h1,        4'd8},  // R8 set on match
    '{2'd0, 5'h04, 32'h0, 32'h0,        4'd8},
    '{2'd1, 5'h04, 32'h0, 32'h1,        4'd8},  // R8 write 0 no effect
    '{2'd0, 5'h04, 32'h1, 32'h0,        4'd8},
    '{2'd1, 5'h04, 32'h0, 32'h0,        4'd8},  // R8 w1c
    '{2'd2, 5'h00, 32'd7, 32'h0,        4'd3},
    '{2'd1, 5'h10, 32'h0, 32'd0,        4'd3},  // R3
    '{2'd2, 5'h00, 32'd1, 32'h0,        4'd4},
    '{2'd1, 5'h10, 32'h0, 32'd10,       4'd4},  // R4 reload
    '{2'd1, 5'h04, 32'h0, 32'h0,        4'd8},  // R8 no match seen
    '{2'd0, 5'h00, 32'h01000003, 32'h0, 4'd5},
    '{2'd2, 5'h00, 32'd11, 32'h0,       4'd5},
    '{2'd1, 5'h10, 32'h0, 32'hFFFFFFFF, 4'd5},  // R5 wrap
    '{2'd1, 5'h04, 32'h0, 32'h1,        4'd8},  // R8
    '{2'd0, 5'h04, 32'h1, 32'h0,        4'd8},
    '{2'd0, 5'h00, 32'h00000003, 32'h0, 4'd10},
    '{2'd2, 5'h00, 32'd5, 32'h0,        4'd10},
    '{2'd1, 5'h10, 32'h0, 32'hFFFFFFFF, 4'd10}, // R10 source off
    '{2'd0, 5'h00, 32'h02000003, 32'h0, 4'd3},
    '{2'd2, 5'h00, 32'd2, 32'h0,        4'd3},
    '{2'd1, 5'h10, 32'h0, 32'hFFFFFFFF, 4'd3},  // R3 other source ignored
    '{2'd3, 5'h00, 32'd2, 32'h0,        4'd3},
    '{2'd1, 5'h10, 32'h0, 32'hFFFFFFFD, 4'd3},  // R3 hf source
    '{2'd0, 5'h00, 32'h01020003, 32'h0, 4'd7},
    '{2'd0, 5'h08, 32'h20, 32'h0,       4'd7},
    '{2'd1, 5'h10, 32'h0, 32'h20,       4'd7},  // R7 overwrite
    '{2'd0, 5'h00, 32'h01000003, 32'h0, 4'd7},
    '{2'd0, 5'h08, 32'h30, 32'h0,       4'd7},
    '{2'd1, 5'h10, 32'h0, 32'h20,       4'd7},  // R7 no overwrite
    '{2'd1, 5'h08, 32'h0, 32'h30,       4'd7},  // R7
    '{2'd0, 5'h00, 32'h01000000, 32'h0, 4'd6},
    '{2'd0, 5'h00, 32'h01000001, 32'h0, 4'd6},
    '{2'd1, 5'h10, 32'h0, 32'h20,       4'd6},  // R6 no enable-mode
    '{2'd2, 5'h00, 32'd1, 32'h0,        4'd3},
    '{2'd1, 5'h10, 32'h0, 32'h1F,       4'd3}   // R3
  };

  task automatic chk(input int rq, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL R%0d: actual %h expected %h", rq, act, exp);
    end
  endtask

  // all tasks start and end at a falling edge, one op per clock
  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic tk(input int n, input bit hf);
    if (hf) tick_hf = 1'b1; else tick_bus = 1'b1;
    repeat (n) @(negedge clk);
    tick_hf = 1'b0; tick_bus = 1'b0;
  endtask

  initial begin
    repeat (2000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, c0;
    logic [31:0] run_bit [3];
    run_bit[0] = 32'h00200000;
    run_bit[1] = 32'h00080000;
    run_bit[2] = 32'h00040000;

    repeat (3) @(negedge clk);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      case (VEC[i].op)
        2'd0: wr(VEC[i].addr, VEC[i].data);
        2'd1: begin rd(VEC[i].addr, v); chk(int'(VEC[i].rq), v, VEC[i].exp); end
        2'd2: tk(int'(VEC[i].data), 1'b0);
        default: tk(int'(VEC[i].data), 1'b1);
      endcase
    end

    // R9 interrupt follows flag and enable; counter is 0x1F here
    wr(5'h0C, 32'h1E);
    wr(5'h00, 32'h01000005);
    chk(9, {31'b0, irq}, 32'h0);
    tk(1, 1'b0);
    chk(9, {31'b0, irq}, 32'h1);
    wr(5'h00, 32'h01000001);
    chk(9, {31'b0, irq}, 32'h0);
    wr(5'h04, 32'h1);

    // R10 low-power gating with and without run permission
    for (int m = 0; m < 3; m++) begin
      stop_req = (m == 0); wait_req = (m == 1); dbg_req = (m == 2);
      wr(5'h00, 32'h01000001);
      rd(5'h10, c0);
      tk(2, 1'b0);
      rd(5'h10, v);
      chk(10, v, c0);
      wr(5'h00, 32'h01000001 | run_bit[m]);
      tk(2, 1'b0);
      rd(5'h10, v);
      chk(10, v, c0 - 32'd2);
      stop_req = 0; wait_req = 0; dbg_req = 0;
    end

    // R11 soft reset: back-to-back ops land inside the 3-cycle window
    wr(5'h08, 32'h44);
    wr(5'h00, 32'h01010001);
    rd(5'h00, v); chk(11, v, 32'h00010000);
    wr(5'h08, 32'h5);
    rd(5'h00, v); chk(11, v, 32'h00010000);
    rd(5'h00, v); chk(11, v, 32'h0);
    rd(5'h08, v); chk(11, v, 32'hFFFFFFFF);
    rd(5'h10, v); chk(11, v, 32'hFFFFFFFF);
    wr(5'h0C, 32'h9);
    rd(5'h0C, v); chk(11, v, 32'h9);

    // R1 hardware reset mid-run
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd(5'h0C, v); chk(1, v, 32'h0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule